// File: doc/BRIEF.md
# Latency-Slotted Result Writeback Queue

This block sits between the execution units of a microcoded vector processor and its 128-entry register file. Execution units hand over a result in the same cycle the instruction issues. The queue parks that result in a seven-slot ring, in the slot that the ring pointer will reach after the operation's fixed latency. The result then waits there until the pointer arrives.

On every issue cycle the slot under the pointer is presented to the register file. The destination field of the instruction issuing in that cycle selects the register that receives it. The destination therefore names where the value now leaving the pipeline goes, not where the current instruction's own result will land. The microcode compiler schedules destinations with this in mind.

A vector-output instruction leaves the ring untouched. A no-operation still moves the ring along. A zero destination discards the departing value.

Top module: `wbq_writeback`

## Requirements
- R1: A synchronous active-high reset empties every slot to zero and returns the pointer to slot 0. After reset, every readout returns zero until new results are inserted.
- R2: The opcode field is 4 bits wide. Its encoding is: 0 no-op, 1 add, 2 subtract, 3 multiply, 4 absolute value, 5 float-to-int, 6 int-to-float, 7 vector output, 8 sine, 9 cosine, 10 compare-above, 11 compare-equal, 12 copy, 13 select, 14 sign-transfer, 15 inverse-sqrt seed. The latency is 5 for add and subtract, 7 for multiply, 3 for int-to-float, and 4 for sine and cosine. Every other computing opcode has latency 2. A result with latency L is read out on the L-th queue-advancing issue after its own issue.
- R3: In an issue cycle that advances the queue with a nonzero destination, `rf_we` is high and `rf_addr` equals the destination. `rf_data` equals the value in the slot under the pointer. All three are valid combinationally in that same cycle.
- R4: A destination of 0 holds `rf_we` low. The departing slot is still cleared, and the pointer still advances.
- R5: After a slot is read out, it holds zero until a later insert targets it.
- R6: A no-op inserts nothing, but it still drains the current slot and advances the pointer.
- R7: A vector-output instruction holds `rf_we` low. It does not clear or advance the ring, and it inserts nothing.
- R8: Without `issue_valid`, `rf_we` stays low and the ring state is unchanged.
- R9: The latency-7 insert targets the slot being vacated in that same cycle. The insert wins over the clear, so the result emerges seven advancing issues later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| opcode | input | 4 | Opcode of the issuing instruction |
| dest | input | 7 | Destination register field of the issuing instruction |
| result | input | 32 | Result computed for the issuing instruction |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 7 | Register-file write address |
| rf_data | output | 32 | Register-file write data (slot under the pointer) |

## Verification
The writeback outputs are combinational from the slot under the pointer. A value inserted with latency L therefore shows on `rf_data` during the L-th queue-advancing issue after its own issue. Vector-output and idle cycles are not counted. The bench drives each instruction just after a falling edge and samples the outputs one time unit later, before the rising edge that updates the ring. The expected data for every table row is the result scheduled for that advancing-issue index, or zero when nothing is scheduled there. The directed tests use the same counting for idle gaps, dropped destinations, a reset in the middle of a run, and a vector output with a result pending.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

    localparam int WBQ_DEPTH  = 7;
    localparam int WBQ_DATA_W = 32;
    localparam int WBQ_REG_AW = 7;
    localparam int WBQ_LAT_W  = $clog2(WBQ_DEPTH + 1);

    typedef enum logic [3:0] {
        OPC_IDLE   = 4'd0,
        OPC_ADD    = 4'd1,
        OPC_SUB    = 4'd2,
        OPC_MUL    = 4'd3,
        OPC_MAG    = 4'd4,
        OPC_TOINT  = 4'd5,
        OPC_TOFLT  = 4'd6,
        OPC_EMIT   = 4'd7,
        OPC_SINE   = 4'd8,
        OPC_COSINE = 4'd9,
        OPC_GREATER= 4'd10,
        OPC_SAME   = 4'd11,
        OPC_MOVE   = 4'd12,
        OPC_PICK   = 4'd13,
        OPC_SIGNX  = 4'd14,
        OPC_RSQSEED= 4'd15
    } opc_e;

    localparam int LAT_ADDSUB = 5;
    localparam int LAT_MUL    = 7;
    localparam int LAT_TOFLT  = 3;
    localparam int LAT_TRIG   = 4;
    localparam int LAT_SHORT  = 2;

    typedef struct packed {
        logic                 advance;
        logic                 insert;
        logic [WBQ_LAT_W-1:0] lat;
    } sched_t;

    function automatic logic [WBQ_LAT_W-1:0] opc_latency(input opc_e op);
        logic [WBQ_LAT_W-1:0] l;
        unique case (op)
            OPC_IDLE, OPC_EMIT:   l = '0;
            OPC_ADD, OPC_SUB:     l = WBQ_LAT_W'(LAT_ADDSUB);
            OPC_MUL:              l = WBQ_LAT_W'(LAT_MUL);
            OPC_TOFLT:            l = WBQ_LAT_W'(LAT_TOFLT);
            OPC_SINE, OPC_COSINE: l = WBQ_LAT_W'(LAT_TRIG);
            default:              l = WBQ_LAT_W'(LAT_SHORT);
        endcase
        return l;
    endfunction

endpackage

// File: rtl/wbq_op_decode.sv
module wbq_op_decode
    import wbq_pkg::*;
(
    input  logic         issue_valid,
    input  logic [3:0]   opcode,
    output sched_t       sched
);
    opc_e op;

    always_comb begin
        op            = opc_e'(opcode);
        sched.advance = issue_valid && (op != OPC_EMIT);
        sched.insert  = issue_valid && (op != OPC_EMIT) && (op != OPC_IDLE);
        sched.lat     = opc_latency(op);
    end
endmodule

// File: rtl/wbq_slot_ring.sv
module wbq_slot_ring #(
    parameter int DEPTH  = 7,
    parameter int DATA_W = 32,
    parameter int LAT_W  = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int SUM_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              insert,
    input  logic [LAT_W-1:0]  lat,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head_data,
    output logic [PTR_W-1:0]  ptr
);
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_nxt;
    logic [SUM_W-1:0]  ins_sum;
    logic [PTR_W-1:0]  ins_idx;

    // Pointer after this issue, modulo DEPTH.
    always_comb begin
        ptr_nxt = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end

    // Target slot = (ptr + 1 + lat - 1) mod DEPTH = (ptr + lat) mod DEPTH.
    always_comb begin
        ins_sum = SUM_W'(ptr_q) + SUM_W'(lat);
        if (ins_sum >= SUM_W'(DEPTH)) begin
            ins_idx = PTR_W'(ins_sum - SUM_W'(DEPTH));
        end else begin
            ins_idx = PTR_W'(ins_sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= ptr_nxt;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (insert && (ins_idx == PTR_W'(g))) begin
                // Insert has priority over the clear of the vacated slot.
                slot_q[g] <= wdata;
            end else if (advance && (ptr_q == PTR_W'(g))) begin
                slot_q[g] <= '0;
            end
        end
    end

    assign head_data = slot_q[ptr_q];
    assign ptr       = ptr_q;
endmodule

// File: rtl/wbq_writeback.sv
module wbq_writeback
    import wbq_pkg::*;
#(
    parameter int DATA_W = WBQ_DATA_W,
    parameter int REG_AW = WBQ_REG_AW,
    parameter int DEPTH  = WBQ_DEPTH,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [3:0]        opcode,
    input  logic [REG_AW-1:0] dest,
    input  logic [DATA_W-1:0] result,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_data
);
    sched_t            sched;
    logic [DATA_W-1:0] head_data;
    logic [PTR_W-1:0]  ring_ptr;

    wbq_op_decode u_decode (
        .issue_valid (issue_valid),
        .opcode      (opcode),
        .sched       (sched)
    );

    wbq_slot_ring #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .LAT_W  (WBQ_LAT_W)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .advance   (sched.advance),
        .insert    (sched.insert),
        .lat       (sched.lat),
        .wdata     (result),
        .head_data (head_data),
        .ptr       (ring_ptr)
    );

    assign rf_we   = sched.advance && (dest != '0);
    assign rf_addr = dest;
    assign rf_data = head_data;
endmodule

// File: rtl/wbq_checker.sv
module wbq_checker #(
    parameter int DEPTH  = 7,
    parameter int REG_AW = 7,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic [3:0]        opcode,
    input logic [REG_AW-1:0] dest,
    input logic              rf_we,
    input logic [PTR_W-1:0]  ptr
);
    p_reset_ptr_r1: assert property (@(posedge clk)
        rst |=> (ptr == '0));

    p_ptr_bound_r2: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ptr} < (PTR_W + 1)'(DEPTH)));

    p_dest_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (dest == '0) |-> !rf_we);

    p_advance_r6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && opcode != 4'd7) |=>
        (ptr == (($past(ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)));

    p_emit_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && opcode == 4'd7) |-> !rf_we);

    p_emit_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && opcode == 4'd7) |=> $stable(ptr));

    p_idle_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> !rf_we);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> $stable(ptr));
endmodule

bind wbq_writeback wbq_checker #(
    .DEPTH  (DEPTH),
    .REG_AW (REG_AW)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .opcode      (opcode),
    .dest        (dest),
    .rf_we       (rf_we),
    .ptr         (ring_ptr)
);

// File: tb/wbq_writeback_tb.sv
module wbq_writeback_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 30;

    typedef struct packed {
        logic [3:0]  op;
        logic [6:0]  dst;
        logic [31:0] res;
        logic        we;
        logic [31:0] data;
    } vec_t;

    // Advancing-issue index a noted per row; data = result scheduled for a.
    localparam vec_t VECS [NVEC] = '{
        '{4'd12, 7'd0,  32'h11110001, 1'b0, 32'h0},          // a0 copy  -> a2
        '{4'd1,  7'd5,  32'h22220002, 1'b1, 32'h0},          // a1 add   -> a6
        '{4'd0,  7'd9,  32'hDEAD0000, 1'b1, 32'h11110001},   // a2 R6
        '{4'd3,  7'd10, 32'h33330003, 1'b1, 32'h0},          // a3 mul   -> a10 (R9)
        '{4'd7,  7'd11, 32'h44440004, 1'b0, 32'h0},          // emit R7, no advance
        '{4'd6,  7'd12, 32'h55550005, 1'b1, 32'h0},          // a4 itof  -> a7
        '{4'd8,  7'd0,  32'h66660006, 1'b0, 32'h0},          // a5 sine  -> a9
        '{4'd4,  7'd13, 32'h77770007, 1'b1, 32'h22220002},   // a6 abs   -> a8
        '{4'd0,  7'd14, 32'hDEAD0000, 1'b1, 32'h55550005},   // a7
        '{4'd0,  7'd15, 32'hDEAD0000, 1'b1, 32'h77770007},   // a8
        '{4'd0,  7'd0,  32'hDEAD0000, 1'b0, 32'h66660006},   // a9 R4
        '{4'd0,  7'd16, 32'hDEAD0000, 1'b1, 32'h33330003},   // a10 R9
        '{4'd0,  7'd17, 32'hDEAD0000, 1'b1, 32'h0},          // a11 R5
        '{4'd0,  7'd18, 32'hDEAD0000, 1'b1, 32'h0},          // a12
        '{4'd0,  7'd19, 32'hDEAD0000, 1'b1, 32'h0},          // a13 R5
        '{4'd2,  7'd0,  32'h88880008, 1'b0, 32'h0},          // a14 sub  -> a19
        '{4'd5,  7'd0,  32'hAAAA000A, 1'b0, 32'h0},          // a15 toint-> a17
        '{4'd15, 7'd0,  32'hBBBB000B, 1'b0, 32'h0},          // a16 seed -> a18
        '{4'd0,  7'd20, 32'hDEAD0000, 1'b1, 32'hAAAA000A},   // a17
        '{4'd0,  7'd21, 32'hDEAD0000, 1'b1, 32'hBBBB000B},   // a18
        '{4'd9,  7'd22, 32'h99990009, 1'b1, 32'h88880008},   // a19 cos  -> a23
        '{4'd10, 7'd0,  32'hCCCC000C, 1'b0, 32'h0},          // a20 gt   -> a22
        '{4'd0,  7'd0,  32'hDEAD0000, 1'b0, 32'h0},          // a21
        '{4'd0,  7'd23, 32'hDEAD0000, 1'b1, 32'hCCCC000C},   // a22
        '{4'd11, 7'd24, 32'hDDDD000D, 1'b1, 32'h99990009},   // a23 eq   -> a25
        '{4'd14, 7'd0,  32'hEEEE000E, 1'b0, 32'h0},          // a24 sgn  -> a26
        '{4'd13, 7'd25, 32'hFFFF000F, 1'b1, 32'hDDDD000D},   // a25 pick -> a27
        '{4'd0,  7'd26, 32'hDEAD0000, 1'b1, 32'hEEEE000E},   // a26
        '{4'd0,  7'd27, 32'hDEAD0000, 1'b1, 32'hFFFF000F},   // a27
        '{4'd7,  7'd30, 32'h12121212, 1'b0, 32'h0}           // emit R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [6:0]  dest = 7'd0;
    logic [31:0] result = 32'h0;
    logic        rf_we;
    logic [6:0]  rf_addr;
    logic [31:0] rf_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wbq_writeback dut_i (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .opcode      (opcode),
        .dest        (dest),
        .result      (result),
        .rf_we       (rf_we),
        .rf_addr     (rf_addr),
        .rf_data     (rf_data)
    );

    task automatic drive(input logic [3:0] op, input logic [6:0] dst, input logic [31:0] res);
        @(negedge clk);
        issue_valid = 1'b1;
        opcode      = op;
        dest        = dst;
        result      = res;
        #1;
    endtask

    task automatic idle(input logic [6:0] dst);
        @(negedge clk);
        issue_valid = 1'b0;
        opcode      = 4'd0;
        dest        = dst;
        #1;
    endtask

    task automatic check(input string req, input logic exp_we, input logic [6:0] exp_addr,
                         input logic [31:0] exp_data, input bit cmp_data);
        bit bad;
        n_checks++;
        bad = (rf_we !== exp_we) || (exp_we && rf_addr !== exp_addr) ||
              (cmp_data && rf_data !== exp_data);
        if (bad) begin
            n_fail++;
            $display("FAIL %s: we=%0b addr=%0d data=%08h expected we=%0b addr=%0d data=%08h",
                     req, rf_we, rf_addr, rf_data, exp_we, exp_addr, exp_data);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        idle(7'd3);
        check("R1 reset idle", 1'b0, 7'd0, 32'h0, 1'b1);

        // Table walk: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].op, VECS[i].dst, VECS[i].res);
            check($sformatf("R2 R3 vector %0d", i), VECS[i].we, VECS[i].dst, VECS[i].data, 1'b1);
        end

        // R8: idle cycles neither write nor move the ring
        drive(4'd12, 7'd0, 32'h0BADCAFE);
        check("R8 insert", 1'b0, 7'd0, 32'h0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            idle(7'd33);
            check("R8 idle", 1'b0, 7'd0, 32'h0, 1'b1);
        end
        drive(4'd0, 7'd40, 32'h0);
        check("R8 first", 1'b1, 7'd40, 32'h0, 1'b1);
        drive(4'd0, 7'd41, 32'h0);
        check("R8 second", 1'b1, 7'd41, 32'h0BADCAFE, 1'b1);

        // R4 and R5: dropped destination still drains
        drive(4'd12, 7'd0, 32'h5A5A5A5A);
        drive(4'd0, 7'd0, 32'h0);
        check("R4 dest zero a", 1'b0, 7'd0, 32'h0, 1'b1);
        drive(4'd0, 7'd0, 32'h0);
        check("R4 dest zero b", 1'b0, 7'd0, 32'h5A5A5A5A, 1'b1);
        for (int k = 0; k < 7; k++) begin
            drive(4'd0, 7'd42, 32'h0);
            check("R5 cleared", 1'b1, 7'd42, 32'h0, 1'b1);
        end

        // R1: reset in the middle of a run discards pending results
        drive(4'd3, 7'd0, 32'h13579BDF);
        @(negedge clk);
        issue_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 7; k++) begin
            drive(4'd0, 7'd43, 32'h0);
            check("R1 mid-run reset", 1'b1, 7'd43, 32'h0, 1'b1);
        end

        // R7: emit with a pending result does not advance
        drive(4'd12, 7'd0, 32'h2468ACE0);
        drive(4'd7, 7'd44, 32'h0);
        check("R7 emit", 1'b0, 7'd0, 32'h0, 1'b1);
        drive(4'd0, 7'd45, 32'h0);
        check("R7 after emit a", 1'b1, 7'd45, 32'h0, 1'b1);
        drive(4'd0, 7'd46, 32'h0);
        check("R7 after emit b", 1'b1, 7'd46, 32'h2468ACE0, 1'b1);

        idle(7'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule